// File: doc/BRIEF.md
# USB Host Interrupt Event and Mask Controller

This block holds the interrupt event state of a USB host controller. Hardware event pulses are captured into sticky status bits. Each event has an enable bit. Software reaches the enable mask through two register aliases: one only sets bits and the other only clears them. A master enable bit gates the single interrupt output.

A simple register bus reaches four words at fixed offsets: command/status (0x08), event status (0x0C), mask-set alias (0x10) and mask-clear alias (0x14). Software asks for an ownership change through a command bit, and the block turns that request into an event. A 2-bit counter in the command/status word counts scheduling-overrun events.

Top module: `usbh_irq_ctrl`

## Requirements
- R1: After reset, every mapped word reads 0 and `irq_o` is low.
- R2: A high on `evt_i[k]` (k = 0..6) sets status bit k at the next clock edge. Bits 0..6 are, in order: scheduling overrun, done-head writeback, start of frame, resume detected, unrecoverable error, frame-number overflow, root-hub status change. The bit stays set until software clears it.
- R3: Writing the status word (0x0C) clears each status bit written as 1. Bits written as 0 keep their value.
- R4: If an event pulse and a write-1-to-clear of the same status bit fall in the same cycle, the bit ends set.
- R5: Writing 1 to a bit of the set alias (0x10) sets that mask bit. Event enables sit at the status positions (0..6 and 30), and the master enable is bit 31. Writing 0 leaves a mask bit unchanged.
- R6: Writing 1 to a bit of the clear alias (0x14) clears that mask bit. Writing 0 leaves it unchanged, and this includes a 0 in master-enable bit 31.
- R7: A read of either 0x10 or 0x14 returns the current mask.
- R8: `irq_o` is high exactly when the master enable is 1 and at least one set status bit has its mask bit set.
- R9: Writing 1 to bit 3 of the command/status word (0x08) sets ownership-change status bit 30 at the next edge.
- R10: Bits 7:6 of the command/status word hold a 2-bit count. The count increments on each scheduling-overrun pulse and wraps from 3 to 0. Bus writes do not change it.
- R11: Unmapped offsets read 0, and writes to them change no state. Unused bits of the mapped words read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 8 | Byte offset of the word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, valid in the same cycle |
| evt_i | input | 7 | Hardware event pulses, positions as in R2 |
| irq_o | output | 1 | Gated interrupt request |

## Verification
On every cycle, the assertions check these behaviours: a pulse sets its status bit, a status bit stays set while no clear is written, the mask stays unchanged without an alias write, a 0 in bit 31 of the clear alias leaves the master enable in place, the ownership request raises bit 30, and the counter steps or holds. Only the bench scenarios can show the following: the read values through both aliases, the write-1-to-clear pattern with mixed bits, set winning over clear in the same cycle, the counter wrap seen across several pulses, and the full gating of the interrupt as mask, master enable and status change in turn.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int HW_EVT  = 7;
  localparam int EVT_N   = HW_EVT + 1;
  localparam int MASK_N  = EVT_N + 1;
  localparam int OC_POS  = 30;
  localparam int MIE_POS = 31;
  localparam int OCR_POS = 3;
  localparam int OVR_LSB = 6;
  localparam int OVR_W   = 2;

  localparam logic [ADDR_W-1:0] OFF_CMD  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_EN   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_DIS  = 8'h14;

  // compact event index -> bit position in the status/mask word
  function automatic int evt_pos(int i);
    return (i < HW_EVT) ? i : OC_POS;
  endfunction

  function automatic logic [EVT_N-1:0] pack_evt(logic [DATA_W-1:0] w);
    logic [EVT_N-1:0] v;
    for (int i = 0; i < EVT_N; i++) v[i] = w[evt_pos(i)];
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] unpack_evt(logic [EVT_N-1:0] v);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int i = 0; i < EVT_N; i++) w[evt_pos(i)] = v[i];
    return w;
  endfunction
endpackage

// File: rtl/usbh_irq_bit_array.sv
module usbh_irq_bit_array #(
  parameter int N        = 8,
  parameter bit SET_WINS = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    if (SET_WINS) begin : g_set_pri
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)       q <= 1'b0;
        else if (set_i[i]) q <= 1'b1;
        else if (clr_i[i]) q <= 1'b0;
    end else begin : g_clr_pri
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)       q <= 1'b0;
        else if (clr_i[i]) q <= 1'b0;
        else if (set_i[i]) q <= 1'b1;
    end
    assign q_o[i] = q;
  end
endmodule

// File: rtl/usbh_irq_ovr_cnt.sv
module usbh_irq_ovr_cnt #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  // natural wrap at 2**W
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + W'(1);

  assign cnt_o = cnt_q;
endmodule

// File: rtl/usbh_irq_reg_if.sv
module usbh_irq_reg_if
  import usbh_irq_pkg::*;
(
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] stat_word_i,
  input  logic [DATA_W-1:0] mask_word_i,
  input  logic [OVR_W-1:0]  ovr_cnt_i,
  output logic [MASK_N-1:0] mask_set_o,
  output logic [MASK_N-1:0] mask_clr_o,
  output logic [EVT_N-1:0]  stat_clr_o,
  output logic              oc_req_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic wr;
  logic [MASK_N-1:0] wmask;

  assign wr    = req_i & we_i;
  assign wmask = {wdata_i[MIE_POS], pack_evt(wdata_i)};

  assign mask_set_o = (wr && addr_i == OFF_EN)   ? wmask : '0;
  assign mask_clr_o = (wr && addr_i == OFF_DIS)  ? wmask : '0;
  assign stat_clr_o = (wr && addr_i == OFF_STAT) ? pack_evt(wdata_i) : '0;
  assign oc_req_o   = wr && addr_i == OFF_CMD && wdata_i[OCR_POS];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_CMD:          rdata_o[OVR_LSB +: OVR_W] = ovr_cnt_i;
      OFF_STAT:         rdata_o = stat_word_i;
      OFF_EN, OFF_DIS:  rdata_o = mask_word_i;
      default:          rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/usbh_irq_ctrl.sv
module usbh_irq_ctrl
  import usbh_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [HW_EVT-1:0] evt_i,
  output logic              irq_o
);
  logic [EVT_N-1:0]  status_q, stat_clr;
  logic [MASK_N-1:0] mask_q, mask_set, mask_clr;
  logic [OVR_W-1:0]  ovr_cnt;
  logic              oc_req;
  logic [DATA_W-1:0] stat_word, mask_word;

  usbh_irq_reg_if u_reg_if (
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .stat_word_i (stat_word),
    .mask_word_i (mask_word),
    .ovr_cnt_i   (ovr_cnt),
    .mask_set_o  (mask_set),
    .mask_clr_o  (mask_clr),
    .stat_clr_o  (stat_clr),
    .oc_req_o    (oc_req),
    .rdata_o     (rdata_o)
  );

  usbh_irq_bit_array #(.N(EVT_N), .SET_WINS(1'b1)) u_status (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i ({oc_req, evt_i}),
    .clr_i (stat_clr),
    .q_o   (status_q)
  );

  usbh_irq_bit_array #(.N(MASK_N), .SET_WINS(1'b1)) u_mask (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (mask_set),
    .clr_i (mask_clr),
    .q_o   (mask_q)
  );

  usbh_irq_ovr_cnt #(.W(OVR_W)) u_ovr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (evt_i[0]),
    .cnt_o (ovr_cnt)
  );

  assign stat_word = unpack_evt(status_q);
  assign mask_word = unpack_evt(mask_q[EVT_N-1:0])
                   | (DATA_W'(mask_q[EVT_N]) << MIE_POS);

  assign irq_o = mask_q[EVT_N] & |(status_q & mask_q[EVT_N-1:0]);
endmodule

// File: rtl/usbh_irq_ctrl_chk.sv
module usbh_irq_ctrl_chk
  import usbh_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [HW_EVT-1:0] evt_i,
  input logic              irq_o,
  input logic [DATA_W-1:0] stat_word,
  input logic [DATA_W-1:0] mask_word,
  input logic [OVR_W-1:0]  ovr_cnt
);
  logic wr_stat, wr_en, wr_dis, wr_cmd;
  assign wr_stat = req_i && we_i && addr_i == OFF_STAT;
  assign wr_en   = req_i && we_i && addr_i == OFF_EN;
  assign wr_dis  = req_i && we_i && addr_i == OFF_DIS;
  assign wr_cmd  = req_i && we_i && addr_i == OFF_CMD;

  AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((stat_word[HW_EVT-1:0] & $past(evt_i)) == $past(evt_i))); // R2
  AST_STAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stat |=> ((stat_word & $past(stat_word)) == $past(stat_word))); // R3
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en || wr_dis) |=> $stable(mask_word)); // R5
  AST_MIE_ZERO_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dis && !wdata_i[MIE_POS] && mask_word[MIE_POS]) |=> mask_word[MIE_POS]); // R6
  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_word[MIE_POS] && (stat_word & mask_word) != '0)); // R8
  AST_OC_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && wdata_i[OCR_POS]) |=> stat_word[OC_POS]); // R9
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[0] |=> ovr_cnt == OVR_W'($past(ovr_cnt) + 1'b1)); // R10
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i[0] |=> $stable(ovr_cnt)); // R10
endmodule

bind usbh_irq_ctrl usbh_irq_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .evt_i    (evt_i),
  .irq_o    (irq_o),
  .stat_word(stat_word),
  .mask_word(mask_word),
  .ovr_cnt  (ovr_cnt)
);

// File: tb/tb_usbh_irq_ctrl.sv
`timescale 1ns/1ps
module tb_usbh_irq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [6:0]  evt_i = '0;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  int exp_cnt = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  usbh_irq_ctrl dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    req_i = 0;
  endtask

  task automatic pulse(logic [6:0] e);
    @(negedge clk_i);
    evt_i = e;
    if (e[0]) exp_cnt = (exp_cnt + 1) % 4;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  task automatic clean();
    bus_wr(8'h0C, 32'hFFFF_FFFF);
    bus_wr(8'h14, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(8'h08, d); check("R1 cmd", d, 0);
    bus_rd(8'h0C, d); check("R1 status", d, 0);
    bus_rd(8'h10, d); check("R1 mask", d, 0);
    check("R1 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_events();
    logic [31:0] d, exp;
    exp = 0;
    for (int k = 1; k < 7; k++) begin
      pulse(7'(1 << k));
      exp |= 32'(1 << k);
      bus_rd(8'h0C, d); check("R2 event latch", d, exp);
    end
    repeat (3) @(negedge clk_i);
    bus_rd(8'h0C, d); check("R2 sticky", d, exp);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    bus_wr(8'h0C, 32'h0000_0014);
    bus_rd(8'h0C, d); check("R3 w1c", d, 32'h0000_006A);
    bus_wr(8'h0C, 32'h0);
    bus_rd(8'h0C, d); check("R3 zero write", d, 32'h0000_006A);
    bus_wr(8'h0C, 32'hFFFF_FFFF);
    bus_rd(8'h0C, d); check("R3 clear all", d, 0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = 8'h0C; wdata_i = 32'h4; evt_i = 7'h04;
    @(negedge clk_i);
    req_i = 0; we_i = 0; evt_i = '0;
    bus_rd(8'h0C, d); check("R4 set wins", d, 32'h4);
    bus_wr(8'h0C, 32'h4);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    bus_wr(8'h10, 32'hC000_0045);
    bus_rd(8'h10, d); check("R5 set alias", d, 32'hC000_0045);
    bus_rd(8'h14, d); check("R7 clear alias read", d, 32'hC000_0045);
    bus_wr(8'h10, 32'h0);
    bus_rd(8'h10, d); check("R5 zero write", d, 32'hC000_0045);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    bus_wr(8'h14, 32'h0000_0004);
    bus_rd(8'h14, d); check("R6 clear bit", d, 32'hC000_0041);
    bus_wr(8'h14, 32'h0);
    bus_rd(8'h10, d); check("R6 zero keeps MIE", d, 32'hC000_0041);
    bus_wr(8'h14, 32'h8000_0000);
    bus_rd(8'h10, d); check("R6 clear MIE", d, 32'h4000_0041);
  endtask

  task automatic t_irq();
    clean();
    pulse(7'h08);
    check("R8 no mask", {31'b0, irq_o}, 0);
    bus_wr(8'h10, 32'h8);
    check("R8 no MIE", {31'b0, irq_o}, 0);
    bus_wr(8'h10, 32'h8000_0000);
    check("R8 asserted", {31'b0, irq_o}, 1);
    bus_wr(8'h14, 32'h8);
    check("R8 masked", {31'b0, irq_o}, 0);
    bus_wr(8'h10, 32'h8);
    bus_wr(8'h0C, 32'h8);
    check("R8 status cleared", {31'b0, irq_o}, 0);
  endtask

  task automatic t_oc();
    logic [31:0] d;
    clean();
    bus_wr(8'h08, 32'h8);
    bus_rd(8'h0C, d); check("R9 ownership", d, 32'h4000_0000);
  endtask

  task automatic t_cnt();
    logic [31:0] d;
    for (int i = 0; i < 5; i++) begin
      pulse(7'h01);
      bus_rd(8'h08, d); check("R10 count", d, 32'(exp_cnt) << 6);
    end
    bus_wr(8'h08, 32'h0000_00C0);
    bus_rd(8'h08, d); check("R10 write ignored", d, 32'(exp_cnt) << 6);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    clean();
    bus_wr(8'h10, 32'h8000_0002);
    bus_wr(8'h20, 32'hFFFF_FFFF);
    bus_rd(8'h20, d); check("R11 unmapped read", d, 0);
    bus_rd(8'h10, d); check("R11 mask untouched", d, 32'h8000_0002);
    bus_rd(8'h0C, d); check("R11 status untouched", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_events();
    t_w1c();
    t_set_wins();
    t_mask();
    t_disable();
    t_irq();
    t_oc();
    t_cnt();
    t_unmapped();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule